// File: doc/BRIEF.md
# Translation Service Register Frame

This block is the register frame that software uses to configure an interrupt translation service. It holds a control word with a single enable bit, the command queue base, the command queue write and read offsets, and a bank of table base words. Each table base word describes one in-memory table: its entry size, its type, how many 4 KiB pages it spans, and whether it is valid. The block also decodes a second, separate translation frame. Devices write an event identifier into that frame's only register, and the block forwards it as a one-cycle request to the translation logic.

The command processor and the table memories sit outside the block. The command processor reads the enable level, the queue base, the queue offsets and the per-table entry counts from the block's outputs. It reports its progress back through a read-offset update input. The queue base and the entry counts are snapshots, taken at the moment the service is switched on. A one-cycle kick tells the command processor to start draining the queue.

Requests arrive on a simple bus. The block accepts one request on any cycle that `req_valid` is high, with no back-pressure. Every request, read or write, gets a response in the following cycle, and no access ever produces an error.

Top module: `xlat_svc_regs`

## Requirements
- R1: After reset the enable level, kick, translate request, response strobe, queue base, both queue offsets and all entry counts are zero. An implemented table word t reads back with its type field (bits 58:56) equal to t and its entry-size field (bits 50:48) equal to 3. All its other bits are zero.
- R2: While enabled, writes to the queue base (0x80/0x84) and to any table word are ignored. The control word (0x00) and the write offset (0x88) stay writable.
- R3: An accepted write to the queue base clears the read offset to zero and leaves the write offset unchanged. The write may be to the low half (0x80), the high half (0x84) or the whole 64 bits.
- R4: Setting enable bit 0 of the control word while disabled leaves the read offset unchanged. It snapshots the queue base and every table's entry count, and it raises `cmd_kick` for exactly one cycle. Writing the bit while already enabled produces no kick.
- R5: A table word whose reset value is zero is unimplemented. With the default `IMPL_MASK` of 8'h05, that is every table except 0 and 2. An unimplemented table word reads as zero and ignores all writes.
- R6: On an implemented table word, the read-only bits 58:56 and 50:48 keep their value on every write. A 32-bit write at offset +4 lands in bits 63:32, and a write at offset +0 lands in bits 31:0.
- R7: A table's entry count is 0 when its valid bit 63 is clear. Otherwise it is min(((bits 7:0 + 1) << 12) >> bits 50:48, 2^ID_BITS).
- R8: Every read of the translation frame (`req_frame`=1) returns zero.
- R9: A translation-frame write at offset 0x40, with size code 1 (2 bytes) or 2 (4 bytes), raises `xlat_req` for one cycle in the following cycle, but only while enabled. `xlat_data` then carries the low 16 or 32 bits of the write data, zero-extended. Any other size or offset, or a write while disabled, raises no request.
- R10: Control-frame accesses at reserved offsets, or with a size other than an aligned 4 or 8 bytes, read as zero and change nothing. Size codes: 0=1 B, 1=2 B, 2=4 B, 3=8 B.
- R11: Every accepted request produces `rsp_valid` in the next cycle. `rsp_rdata` is zero for writes. A 4-byte read at offset +4 returns the upper half of the word in bits 31:0.
- R12: `rptr_upd_valid` loads `rptr_upd_off` into the read offset. If a queue-base write is accepted in the same cycle, the clear to zero wins.
- R13: The write offset keeps only bits 19:5 of a low-half or whole write to 0x88, and reads back with every other bit zero. Writes to the read offset register (0x90) are ignored, and it reads back as the offset shifted left by 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_frame | input | 1 | 0 = control frame, 1 = translation frame |
| req_addr | input | ADDR_W | Byte offset within the frame |
| req_size | input | 2 | Access size code (0=1 B, 1=2 B, 2=4 B, 3=8 B) |
| req_wdata | input | 64 | Write data, right-aligned |
| rsp_valid | output | 1 | Response strobe, one cycle after each request |
| rsp_rdata | output | 64 | Read data |
| rptr_upd_valid | input | 1 | Command processor reports a new read offset |
| rptr_upd_off | input | 15 | New read offset in 32-byte units |
| svc_en | output | 1 | Service enable level |
| cmd_kick | output | 1 | One-cycle start pulse on enable |
| cq_base | output | 64 | Queue base snapshot taken at enable |
| cq_wr_off | output | 15 | Live write offset |
| cq_rd_off | output | 15 | Live read offset |
| tbl_entries | output | N_TABLES*(ID_BITS+1) | Per-table entry counts, snapshot at enable |
| xlat_req | output | 1 | Translation request strobe |
| xlat_data | output | 32 | Event identifier for the request |

## Verification
Two functions can land on the read offset in the same cycle: the clear caused by a queue-base write, and a load from the command processor's update input. The bench drives `rptr_upd_valid` in the very cycle it writes the queue base, both while disabled (where the write is accepted) and while enabled (where it is locked). It expects zero in the first case and the update value in the second. The same rule applies to the enable write: a pointer update issued just before the enable must survive it. The behavioural model checks the read offset against these rules on every clock.

// File: rtl/xsr_pkg.sv
// Shared types and constants for the translation service register frame.
// Assumes a little-endian 64-bit register layout and 32-byte command slots.
package xsr_pkg;

    localparam int unsigned QOFF_LSB = 5;
    localparam int unsigned QOFF_W   = 15;

    // Read-only bits of a table word: type (58:56) and log2 entry size (50:48)
    localparam logic [63:0] TBL_RO_MASK = 64'h0707_0000_0000_0000;

    typedef enum logic [2:0] {
        SEL_NONE  = 3'd0,
        SEL_CTRL  = 3'd1,
        SEL_CBASE = 3'd2,
        SEL_WPTR  = 3'd3,
        SEL_RPTR  = 3'd4,
        SEL_TBL   = 3'd5
    } reg_sel_e;

    typedef struct packed {
        logic        rd;
        logic        wr;
        logic        full;
        logic        hi_half;
        reg_sel_e    sel;
        logic [7:0]  tbl_idx;
        logic [63:0] mask64;
        logic [63:0] wval64;
    } acc_t;

    // Reset value of an implemented table word: type = index, 8-byte entries
    function automatic logic [63:0] tbl_reset(int unsigned t);
        logic [63:0] r;
        r = '0;
        r[58:56] = t[2:0];
        r[50:48] = 3'd3;
        return r;
    endfunction

endpackage

// File: rtl/xsr_decode.sv
// Control-frame address decoder.
// Turns one bus request into a register select, a byte-lane mask and
// replicated write data. Only aligned 4- and 8-byte accesses decode;
// everything else selects nothing. Assumes ADDR_W <= 32 and N_TABLES <= 16.
module xsr_decode
    import xsr_pkg::*;
#(
    parameter int unsigned ADDR_W   = 12,
    parameter int unsigned N_TABLES = 8
) (
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_frame,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic [63:0]       req_wdata,
    output acc_t              acc_o
);

    localparam logic [31:0] TBL_LO = 32'h100;
    localparam logic [31:0] TBL_HI = 32'h100 + 32'(8 * N_TABLES);

    logic [31:0] base;
    logic        aligned;

    // Decode the request into select, mask and data
    always_comb begin
        base    = 32'(req_addr) & ~32'h7;
        aligned = ((req_size == 2'd2) && (req_addr[1:0] == 2'b00)) ||
                  ((req_size == 2'd3) && (req_addr[2:0] == 3'b000));
        acc_o     = '0;
        acc_o.sel = SEL_NONE;
        if (req_valid && !req_frame && aligned) begin
            acc_o.rd      = !req_write;
            acc_o.wr      = req_write;
            acc_o.full    = (req_size == 2'd3);
            acc_o.hi_half = (req_size != 2'd3) && req_addr[2];
            acc_o.mask64  = acc_o.full    ? '1 :
                            acc_o.hi_half ? {32'hFFFF_FFFF, 32'h0} :
                                            {32'h0, 32'hFFFF_FFFF};
            acc_o.wval64  = acc_o.full ? req_wdata : {2{req_wdata[31:0]}};
            if (base == 32'h0)
                acc_o.sel = SEL_CTRL;
            else if (base == 32'h80)
                acc_o.sel = SEL_CBASE;
            else if (base == 32'h88)
                acc_o.sel = SEL_WPTR;
            else if (base == 32'h90)
                acc_o.sel = SEL_RPTR;
            else if (base >= TBL_LO && base < TBL_HI) begin
                acc_o.sel     = SEL_TBL;
                acc_o.tbl_idx = 8'((base - TBL_LO) >> 3);
            end
        end
    end

endmodule

// File: rtl/xsr_tbl_base.sv
// One table base word and its entry-count snapshot.
// When IMPL is clear the word does not exist: it reads zero, has no
// storage and reports zero entries. The entry size is a power of two,
// so the count needs only a shift. ID_BITS bounds the count.
module xsr_tbl_base
    import xsr_pkg::*;
#(
    parameter bit          IMPL    = 1'b1,
    parameter int unsigned ID_BITS = 16,
    parameter logic [63:0] RST_VAL = 64'h0003_0000_0000_0000,
    localparam int unsigned CNT_W  = ID_BITS + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [63:0]      wmask_i,
    input  logic [63:0]      wval_i,
    input  logic             latch_i,
    output logic [63:0]      val_o,
    output logic [CNT_W-1:0] cnt_o
);

    generate
        if (IMPL) begin : g_impl
            localparam int unsigned RAW_W = (ID_BITS + 1 > 21) ? ID_BITS + 1 : 21;

            logic [63:0]      baser_q;
            logic [CNT_W-1:0] cnt_q;
            logic [RAW_W-1:0] raw;
            logic [RAW_W-1:0] lim;
            logic [CNT_W-1:0] clamped;
            logic [63:0]      keep;

            // Size-derived entry count, clamped to the ID range
            always_comb begin
                raw     = ((RAW_W'(baser_q[7:0]) + RAW_W'(1)) << 12) >> baser_q[50:48];
                lim     = RAW_W'(1) << ID_BITS;
                clamped = CNT_W'((raw > lim) ? lim : raw);
                keep    = ~wmask_i | TBL_RO_MASK;
            end

            // Table word storage; read-only fields never take write data
            always_ff @(posedge clk) begin
                if (!rst_n)
                    baser_q <= RST_VAL;
                else if (wr_i)
                    baser_q <= (baser_q & keep) | (wval_i & ~keep);
            end

            // Entry-count snapshot taken when the service is enabled
            always_ff @(posedge clk) begin
                if (!rst_n)
                    cnt_q <= '0;
                else if (latch_i)
                    cnt_q <= baser_q[63] ? clamped : '0;
            end

            assign val_o = baser_q;
            assign cnt_o = cnt_q;

            assert_ro_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
                wr_i |=> ((baser_q & TBL_RO_MASK) == $past(baser_q & TBL_RO_MASK)));

            assert_cnt_clamped_R7: assert property (@(posedge clk) disable iff (!rst_n)
                latch_i |=> (RAW_W'(cnt_q) <= lim));
        end else begin : g_absent
            logic unused_inputs;
            assign unused_inputs = ^{clk, rst_n, wr_i, wmask_i, wval_i, latch_i};
            assign val_o = '0;
            assign cnt_o = '0;
        end
    endgenerate

endmodule

// File: rtl/xsr_xlat_port.sv
// Translation frame decoder.
// The frame holds one write-only register at XLAT_OFF. An aligned
// 2- or 4-byte write there, while enabled, becomes a one-cycle request
// in the next cycle. Reads of the frame are answered with zero by the top.
module xsr_xlat_port #(
    parameter int unsigned ADDR_W   = 12,
    parameter int unsigned XLAT_OFF = 32'h40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_frame,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic [31:0]       req_wdata,
    input  logic              en_i,
    output logic              xlat_req_o,
    output logic [31:0]       xlat_data_o
);

    logic        hit;
    logic [31:0] data;
    logic        req_q;
    logic [31:0] data_q;

    // Qualify the translation write and zero-extend its payload
    always_comb begin
        hit  = req_valid && req_write && req_frame && en_i &&
               (32'(req_addr) == XLAT_OFF) &&
               ((req_size == 2'd1) || (req_size == 2'd2));
        data = (req_size == 2'd1) ? {16'h0, req_wdata[15:0]} : req_wdata;
    end

    // Register the request strobe and hold the last event identifier
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q  <= 1'b0;
            data_q <= '0;
        end else begin
            req_q <= hit;
            if (hit)
                data_q <= data;
        end
    end

    assign xlat_req_o  = req_q;
    assign xlat_data_o = data_q;

    assert_xlat_needs_en_R9: assert property (@(posedge clk) disable iff (!rst_n)
        xlat_req_o |-> $past(en_i));

endmodule

// File: rtl/xlat_svc_regs.sv
// Register frame of an interrupt translation service.
// Holds the control word, the command queue base and offsets, and
// N_TABLES table words, and decodes the translation frame. The queue
// base and table words are locked while enabled. Every request is
// accepted at once and answered one cycle later. Assumes N_TABLES >= 2.
module xlat_svc_regs
    import xsr_pkg::*;
#(
    parameter int unsigned          ADDR_W    = 12,
    parameter int unsigned          N_TABLES  = 8,
    parameter logic [N_TABLES-1:0]  IMPL_MASK = 8'h05,
    parameter int unsigned          ID_BITS   = 16,
    localparam int unsigned         CNT_W     = ID_BITS + 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    input  logic                      req_write,
    input  logic                      req_frame,
    input  logic [ADDR_W-1:0]         req_addr,
    input  logic [1:0]                req_size,
    input  logic [63:0]               req_wdata,
    output logic                      rsp_valid,
    output logic [63:0]               rsp_rdata,
    input  logic                      rptr_upd_valid,
    input  logic [QOFF_W-1:0]         rptr_upd_off,
    output logic                      svc_en,
    output logic                      cmd_kick,
    output logic [63:0]               cq_base,
    output logic [QOFF_W-1:0]         cq_wr_off,
    output logic [QOFF_W-1:0]         cq_rd_off,
    output logic [N_TABLES*CNT_W-1:0] tbl_entries,
    output logic                      xlat_req,
    output logic [31:0]               xlat_data
);

    localparam int unsigned IDX_W = $clog2(N_TABLES);

    acc_t              acc;
    logic              en_q, kick_q, rsp_v_q;
    logic [63:0]       cb_q, cbl_q, rsp_d_q, rd64, shaped;
    logic [QOFF_W-1:0] wp_q, rp_q;
    logic              ctrl_wr, en_rise, cb_wr, wp_wr;
    logic [N_TABLES-1:0] tbl_wr;
    logic [63:0]       tbl_val [N_TABLES];
    logic [IDX_W-1:0]  idx;
    logic              unused_idx;

    xsr_decode #(.ADDR_W(ADDR_W), .N_TABLES(N_TABLES)) u_dec (
        .req_valid (req_valid),
        .req_write (req_write),
        .req_frame (req_frame),
        .req_addr  (req_addr),
        .req_size  (req_size),
        .req_wdata (req_wdata),
        .acc_o     (acc)
    );

    assign idx        = acc.tbl_idx[IDX_W-1:0];
    assign unused_idx = ^acc.tbl_idx[7:IDX_W];

    // Write qualifiers, including the lock while enabled
    always_comb begin
        ctrl_wr = acc.wr && (acc.sel == SEL_CTRL) && acc.mask64[0];
        en_rise = ctrl_wr && req_wdata[0] && !en_q;
        cb_wr   = acc.wr && (acc.sel == SEL_CBASE) && !en_q;
        wp_wr   = acc.wr && (acc.sel == SEL_WPTR) && acc.mask64[0];
        for (int t = 0; t < N_TABLES; t++)
            tbl_wr[t] = acc.wr && (acc.sel == SEL_TBL) && (idx == IDX_W'(t)) &&
                        !en_q && IMPL_MASK[t];
    end

    generate
        for (genvar t = 0; t < N_TABLES; t++) begin : g_tbl
            logic [CNT_W-1:0] cnt;
            xsr_tbl_base #(
                .IMPL    (IMPL_MASK[t]),
                .ID_BITS (ID_BITS),
                .RST_VAL (tbl_reset(t))
            ) u_tbl (
                .clk     (clk),
                .rst_n   (rst_n),
                .wr_i    (tbl_wr[t]),
                .wmask_i (acc.mask64),
                .wval_i  (acc.wval64),
                .latch_i (en_rise),
                .val_o   (tbl_val[t]),
                .cnt_o   (cnt)
            );
            assign tbl_entries[t*CNT_W +: CNT_W] = cnt;
        end
    endgenerate

    // Enable level, start pulse and queue-base snapshot
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            kick_q <= 1'b0;
            cbl_q  <= '0;
        end else begin
            kick_q <= en_rise;
            if (ctrl_wr)
                en_q <= req_wdata[0];
            if (en_rise)
                cbl_q <= cb_q;
        end
    end

    // Queue base register, written only while disabled
    always_ff @(posedge clk) begin
        if (!rst_n)
            cb_q <= '0;
        else if (cb_wr)
            cb_q <= (cb_q & ~acc.mask64) | (acc.wval64 & acc.mask64);
    end

    // Read offset: a base write clears it ahead of a processor update
    always_ff @(posedge clk) begin
        if (!rst_n)
            rp_q <= '0;
        else if (cb_wr)
            rp_q <= '0;
        else if (rptr_upd_valid)
            rp_q <= rptr_upd_off;
    end

    // Write offset: keeps only the slot-index bits
    always_ff @(posedge clk) begin
        if (!rst_n)
            wp_q <= '0;
        else if (wp_wr)
            wp_q <= req_wdata[QOFF_LSB +: QOFF_W];
    end

    // Read data select and half-word shaping
    always_comb begin
        case (acc.sel)
            SEL_CTRL:  rd64 = {63'h0, en_q};
            SEL_CBASE: rd64 = cb_q;
            SEL_WPTR:  rd64 = 64'(wp_q) << QOFF_LSB;
            SEL_RPTR:  rd64 = 64'(rp_q) << QOFF_LSB;
            SEL_TBL:   rd64 = tbl_val[idx];
            default:   rd64 = '0;
        endcase
        shaped = acc.full    ? rd64 :
                 acc.hi_half ? {32'h0, rd64[63:32]} : {32'h0, rd64[31:0]};
    end

    // One-cycle response for every request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_v_q <= 1'b0;
            rsp_d_q <= '0;
        end else begin
            rsp_v_q <= req_valid;
            rsp_d_q <= acc.rd ? shaped : '0;
        end
    end

    xsr_xlat_port #(.ADDR_W(ADDR_W)) u_xlat (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_write   (req_write),
        .req_frame   (req_frame),
        .req_addr    (req_addr),
        .req_size    (req_size),
        .req_wdata   (req_wdata[31:0]),
        .en_i        (en_q),
        .xlat_req_o  (xlat_req),
        .xlat_data_o (xlat_data)
    );

    assign svc_en    = en_q;
    assign cmd_kick  = kick_q;
    assign cq_base   = cbl_q;
    assign cq_wr_off = wp_q;
    assign cq_rd_off = rp_q;
    assign rsp_valid = rsp_v_q;
    assign rsp_rdata = rsp_d_q;

    assert_cb_locked_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && acc.wr && acc.sel == SEL_CBASE) |=> $stable(cq_base) && $stable(cb_q));

    assert_cb_clears_rd_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cb_wr |=> (cq_rd_off == '0) && $stable(cq_wr_off));

    assert_en_keeps_rd_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (en_rise && !rptr_upd_valid) |=> $stable(cq_rd_off));

    assert_kick_on_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_kick |-> (svc_en && !$past(svc_en)));

    assert_unimpl_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc.rd && acc.sel == SEL_TBL && !IMPL_MASK[idx]) |=> (rsp_rdata == '0));

    assert_rsp_each_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    assert_xlat_rd_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_frame) |=> (rsp_rdata == '0));

endmodule

// File: tb/tb_xlat_svc_regs.sv
// Self-checking bench: a behavioural model is stepped with each request
// and compared against every DUT output on every falling clock edge.
module tb_xlat_svc_regs;

    localparam int CW = 17;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_write, req_frame;
    logic [11:0] req_addr;
    logic [1:0]  req_size;
    logic [63:0] req_wdata;
    logic        rsp_valid;
    logic [63:0] rsp_rdata;
    logic        rptr_upd_valid;
    logic [14:0] rptr_upd_off;
    logic        svc_en, cmd_kick;
    logic [63:0] cq_base;
    logic [14:0] cq_wr_off, cq_rd_off;
    logic [8*CW-1:0] tbl_entries;
    logic        xlat_req;
    logic [31:0] xlat_data;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    xlat_svc_regs dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_frame(req_frame),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .rptr_upd_valid(rptr_upd_valid), .rptr_upd_off(rptr_upd_off),
        .svc_en(svc_en), .cmd_kick(cmd_kick), .cq_base(cq_base),
        .cq_wr_off(cq_wr_off), .cq_rd_off(cq_rd_off),
        .tbl_entries(tbl_entries), .xlat_req(xlat_req), .xlat_data(xlat_data)
    );

    // ---------------- behavioural model ----------------
    localparam logic [63:0] RO = 64'h0707_0000_0000_0000;
    localparam logic [7:0]  IMPL = 8'h05;
    logic        m_en, m_kick, m_rv, m_xreq;
    logic [63:0] m_cb, m_cbl, m_rd;
    logic [14:0] m_wp, m_rp;
    logic [31:0] m_xd;
    logic [63:0] m_bas [8];
    longint      m_cnt [8];

    function automatic longint cnt_of(logic [63:0] b);
        longint raw;
        if (!b[63]) return 0;
        raw = ((longint'(b[7:0]) + 1) << 12) >> b[50:48];
        return (raw > 65536) ? 65536 : raw;
    endfunction

    function automatic logic [63:0] m_read(int base);
        if (base == 0) return {63'h0, m_en};
        if (base == 'h80) return m_cb;
        if (base == 'h88) return 64'(m_wp) << 5;
        if (base == 'h90) return 64'(m_rp) << 5;
        if (base >= 'h100 && base < 'h140) return m_bas[(base - 'h100) / 8];
        return 64'h0;
    endfunction

    task automatic m_reset();
        m_en = 0; m_kick = 0; m_rv = 0; m_xreq = 0; m_cb = 0; m_cbl = 0;
        m_rd = 0; m_wp = 0; m_rp = 0; m_xd = 0;
        for (int t = 0; t < 8; t++) begin
            m_bas[t] = IMPL[t] ? ((64'(t) << 56) | (64'd3 << 48)) : 64'h0;
            m_cnt[t] = 0;
        end
    endtask

    task automatic m_apply(bit v, bit w, bit f, int a, int sz, logic [63:0] d,
                           bit uv, int uo);
        logic [63:0] rv, mk, wv, keep;
        int base;
        bit half, full, ok, cbw;
        m_kick = 0; m_xreq = 0; m_rv = v; m_rd = 0; cbw = 0;
        if (v && !f) begin
            ok   = (sz == 2 && a % 4 == 0) || (sz == 3 && a % 8 == 0);
            base = a & ~7;
            full = (sz == 3);
            half = !full && ((a & 4) != 0);
            if (ok) begin
                rv = m_read(base);
                mk = full ? '1 : half ? 64'hFFFF_FFFF_0000_0000 : 64'h0000_0000_FFFF_FFFF;
                wv = full ? d : {d[31:0], d[31:0]};
                if (!w)
                    m_rd = full ? rv : half ? (rv >> 32) : (rv & 64'hFFFF_FFFF);
                else if (base == 0 && mk[0]) begin
                    if (d[0] && !m_en) begin
                        m_kick = 1; m_cbl = m_cb;
                        for (int t = 0; t < 8; t++) m_cnt[t] = cnt_of(m_bas[t]);
                    end
                    m_en = d[0];
                end else if (base == 'h80 && !m_en) begin
                    m_cb = (m_cb & ~mk) | (wv & mk); cbw = 1;
                end else if (base == 'h88 && mk[0])
                    m_wp = d[19:5];
                else if (base >= 'h100 && base < 'h140 && !m_en &&
                         IMPL[(base - 'h100) / 8]) begin
                    keep = ~mk | RO;
                    m_bas[(base - 'h100) / 8] = (m_bas[(base - 'h100) / 8] & keep) | (wv & ~keep);
                end
            end
        end
        if (v && f && w && a == 'h40 && (sz == 1 || sz == 2) && m_en) begin
            m_xreq = 1;
            m_xd = (sz == 1) ? {16'h0, d[15:0]} : d[31:0];
        end
        if (cbw) m_rp = 0;
        else if (uv) m_rp = 15'(uo);
    endtask

    // ---------------- compare ----------------
    task automatic fail(string tag, string what, logic [63:0] act, logic [63:0] exp);
        errors++;
        $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    endtask

    task automatic compare(string tag);
        checks++;
        if (svc_en !== m_en) fail(tag, "svc_en", 64'(svc_en), 64'(m_en));
        if (cmd_kick !== m_kick) fail(tag, "cmd_kick", 64'(cmd_kick), 64'(m_kick));
        if (cq_base !== m_cbl) fail(tag, "cq_base", cq_base, m_cbl);
        if (cq_wr_off !== m_wp) fail(tag, "cq_wr_off", 64'(cq_wr_off), 64'(m_wp));
        if (cq_rd_off !== m_rp) fail(tag, "cq_rd_off", 64'(cq_rd_off), 64'(m_rp));
        if (rsp_valid !== m_rv) fail(tag, "rsp_valid", 64'(rsp_valid), 64'(m_rv));
        if (rsp_rdata !== m_rd) fail(tag, "rsp_rdata", rsp_rdata, m_rd);
        if (xlat_req !== m_xreq) fail(tag, "xlat_req", 64'(xlat_req), 64'(m_xreq));
        if (m_xreq && xlat_data !== m_xd) fail(tag, "xlat_data", 64'(xlat_data), 64'(m_xd));
        for (int t = 0; t < 8; t++)
            if (64'(tbl_entries[t*CW +: CW]) !== 64'(m_cnt[t]))
                fail(tag, $sformatf("tbl_entries[%0d]", t),
                     64'(tbl_entries[t*CW +: CW]), 64'(m_cnt[t]));
    endtask

    task automatic step(string tag, bit v, bit w, bit f, int a, int sz,
                        logic [63:0] d, bit uv = 0, int uo = 0);
        req_valid = v; req_write = w; req_frame = f; req_addr = 12'(a);
        req_size = 2'(sz); req_wdata = d; rptr_upd_valid = uv; rptr_upd_off = 15'(uo);
        m_apply(v, w, f, a, sz, d, uv, uo);
        @(negedge clk);
        compare(tag);
    endtask

    task automatic idle(string tag);
        step(tag, 0, 0, 0, 0, 0, 64'h0);
    endtask
    task automatic wr(string tag, int a, int sz, logic [63:0] d);
        step(tag, 1, 1, 0, a, sz, d);
    endtask
    task automatic rd(string tag, int a, int sz);
        step(tag, 1, 0, 0, a, sz, 64'h0);
    endtask

    // ---------------- stimulus ----------------
    initial begin
        rst_n = 0; req_valid = 0; req_write = 0; req_frame = 0; req_addr = 0;
        req_size = 0; req_wdata = 0; rptr_upd_valid = 0; rptr_upd_off = 0;
        m_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state and table reset values
        idle("R1"); idle("R1");
        rd("R1", 'h100, 3); rd("R1", 'h110, 3); rd("R1", 'h00, 2); rd("R1", 'h90, 3);
        // R13 write offset masking, read offset register read-only
        wr("R13", 'h88, 3, '1); rd("R13", 'h88, 3);
        wr("R13", 'h90, 3, '1); rd("R13", 'h90, 3);
        wr("R13", 'h8C, 2, '1); rd("R13", 'h88, 2);
        wr("R13", 'h88, 2, 64'h1240);
        // R3 base writes clear the read offset only
        step("R12", 0, 0, 0, 0, 0, 0, 1, 'h55); rd("R12", 'h90, 2);
        wr("R3", 'h80, 2, 64'h1111_0000);
        step("R12", 0, 0, 0, 0, 0, 0, 1, 'h22);
        wr("R3", 'h84, 2, 64'hABCD);
        step("R12", 0, 0, 0, 0, 0, 0, 1, 7);
        wr("R3", 'h80, 3, 64'h0123_4567_89AB_CDE0);
        rd("R11", 'h80, 3); rd("R11", 'h84, 2); rd("R11", 'h80, 2);
        // R12 base write and pointer update in the same cycle
        step("R12", 0, 0, 0, 0, 0, 0, 1, 'h33);
        step("R12", 1, 1, 0, 'h80, 2, 64'h4000, 1, 'h44);
        idle("R12");
        // R6 read-only fields and upper-half placement
        wr("R6", 'h100, 3, '1); rd("R6", 'h100, 3);
        wr("R6", 'h104, 2, 64'h0); rd("R6", 'h100, 3);
        wr("R6", 'h100, 2, 64'hFFFF_FF00); rd("R6", 'h104, 2);
        wr("R6", 'h114, 2, 64'hFFFF_FFFF); rd("R6", 'h110, 3);
        // R5 unimplemented table words
        wr("R5", 'h108, 3, '1); rd("R5", 'h108, 3);
        wr("R5", 'h138, 2, '1); rd("R5", 'h138, 3); rd("R5", 'h13C, 2);
        // R7 entry-count sizing, then R4 enable snapshot
        wr("R7", 'h100, 3, 64'h8000_0000_0000_00FF);
        wr("R7", 'h110, 3, 64'h8000_0000_0000_0003);
        step("R4", 0, 0, 0, 0, 0, 0, 1, 9);
        wr("R4", 'h00, 2, 64'h1);
        idle("R4"); idle("R7");
        // R2 locks while enabled; control and write offset still writable
        wr("R2", 'h80, 3, 64'h0); rd("R2", 'h80, 3);
        wr("R2", 'h100, 3, 64'h0); rd("R2", 'h100, 3);
        wr("R2", 'h110, 2, 64'h7); rd("R2", 'h110, 3);
        wr("R2", 'h88, 3, 64'h40); rd("R2", 'h88, 3);
        step("R12", 1, 1, 0, 'h80, 3, 64'h0, 1, 'h11);
        // R9 translation requests
        step("R9", 1, 1, 1, 'h40, 2, 64'hDEAD_BEEF); idle("R9");
        step("R9", 1, 1, 1, 'h40, 1, 64'h1234_5678); idle("R9");
        step("R9", 1, 1, 1, 'h40, 0, 64'h55);
        step("R9", 1, 1, 1, 'h40, 3, 64'h66);
        step("R9", 1, 1, 1, 'h44, 2, 64'h77);
        step("R9", 1, 1, 1, 'h40, 2, 64'hCAFE); idle("R9");
        // R8 translation frame reads
        step("R8", 1, 0, 1, 'h40, 2, 64'h0); step("R8", 1, 0, 1, 'h00, 3, 64'h0);
        // R4 re-enable rules
        wr("R4", 'h00, 2, 64'h1);
        step("R4", 0, 0, 0, 0, 0, 0, 1, 3);
        wr("R4", 'h00, 2, 64'h0);
        step("R9", 1, 1, 1, 'h40, 2, 64'hBAD); idle("R9");
        wr("R7", 'h110, 3, 64'h8000_0000_0000_0007);
        wr("R7", 'h100, 3, 64'h0000_0000_0000_0007);
        wr("R4", 'h00, 3, 64'h1);
        idle("R4"); idle("R7");
        // R10 reserved offsets and invalid sizes
        rd("R10", 'h20, 3); rd("R10", 'h82, 2); rd("R10", 'h84, 3);
        step("R10", 1, 0, 0, 'h00, 1, 0); step("R10", 1, 0, 0, 'h00, 0, 0);
        wr("R10", 'h20, 3, '1); rd("R10", 'h20, 3);
        wr("R10", 'h00, 1, 64'h0); rd("R10", 'h00, 2);
        wr("R10", 'h04, 2, 64'h0); rd("R10", 'h00, 3);
        wr("R10", 'h00, 2, 64'h0);
        wr("R10", 'h81, 3, '1); rd("R10", 'h80, 3);
        wr("R10", 'h8A, 2, '1); rd("R10", 'h88, 3);
        idle("R11");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R11 watchdog actual=hung expected=complete");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule